// File: doc/BRIEF.md
# Carry-Save Reduction Tree with Carry-In Absorption

This block reduces eight partial-product words, each with one carry-in bit, to a redundant sum/carry pair. It is built only from 3:2 compressors (full-adder rows) and has no half adders. The carry vector that leaves a compressor row is shifted left by one, so its least significant bit is always free. Each level drops one pending carry-in bit into that free position. The carry-ins therefore ride inside the partial-product tree, and no separate tree sums them.

The tree has four compressor levels. The first level reduces operands 0..2 and 3..5. The second level folds those results together and also folds in operands 6 and 7. The third and fourth levels bring the result down to one sum and one carry. Six carry vectors are produced, so six carry-in bits are absorbed. The two carry-in bits that remain come out unchanged, and a downstream carry-propagate stage adds them. Register banks sit after every level or after every second level, chosen by a parameter. A valid flag travels with the data.

Top module: `csa_absorb_tree`

## Requirements
- R1: While reset is held, and until the first accepted item has crossed the pipeline, `out_vld` is 0.
- R2: An item accepted with `in_vld`=1 at a rising edge appears with `out_vld`=1 right after the LAT-th rising edge, counting the accepting edge as the first. LAT is 4 when one compressor level sits between registers (the default) and 2 when two levels do.
- R3: For each result, `sum_o + carry_o + cin_left[0] + cin_left[1]` equals the sum of all eight operands plus all eight carry-in bits, modulo 2^ACC_W, with ACC_W = PP_W + 3. Operands are unsigned. Operand k occupies bits k*PP_W upward of `pp_in`, and its carry-in is `cin_in[k]`.
- R4: Bit 0 of `carry_o` equals carry-in bit 5 of the same item, and `cin_left` equals {`cin_in[7]`, `cin_in[6]`} of that item.
- R5: One item is accepted per cycle with no stall, and results leave in the order the items entered.
- R6: When exactly one operand is nonzero and all carry-ins are 0, `sum_o` equals that operand and `carry_o` is 0, whatever slot the operand is in.
- R7: Cycles with `in_vld`=0 produce no result, whatever data is on `pp_in` and `cin_in` in those cycles.
- R8: When every operand is all ones and every carry-in is 1, the total is exactly 2^ACC_W, and `sum_o + carry_o + cin_left` wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Item present on the operand inputs |
| pp_in | input | NUM_PP*PP_W (80) | Eight unsigned operands, operand k at bits k*PP_W upward |
| cin_in | input | NUM_PP (8) | Carry-in bit k belongs with operand k |
| out_vld | output | 1 | Result present |
| sum_o | output | ACC_W (13) | Redundant sum word |
| carry_o | output | ACC_W (13) | Redundant carry word; bit 0 holds carry-in 5 |
| cin_left | output | 2 | Unabsorbed carry-ins {7, 6} |

## Verification
With the default grouping, each result is due exactly four rising edges after it is accepted, counting the accepting edge. The driver stamps each expected item with the edge number at which it must appear: the current edge count plus four. The monitor runs on falling edges, pops the oldest item whenever `out_vld` is high, and compares both the edge number and the data. A result that is late, early, missing or unexpected therefore fails a check. Idle windows carry random data with `in_vld` low, so any stray result shows up either as an unexpected pop or through an explicit check of `out_vld`.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

    parameter int unsigned PP_W   = 10;
    parameter int unsigned NUM_PP = 8;

    localparam int unsigned ACC_W    = PP_W + $clog2(NUM_PP);
    localparam int unsigned NUM_LVL  = 4;
    localparam int unsigned NUM_LEFT = 2;

    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic {
        GRP_ONE = 1'b0,
        GRP_TWO = 1'b1
    } grp_e;

    typedef struct packed {
        logic                   vld;
        acc_t [NUM_PP-1:0]      w;
        logic [NUM_PP-1:0]      ci;
    } tree_t;

    // Arithmetic weight of a tree slice: all words plus all pending carry-ins.
    function automatic acc_t tree_total(input tree_t t);
        acc_t acc;
        acc = '0;
        for (int k = 0; k < int'(NUM_PP); k++) begin
            acc = acc + t.w[k] + acc_t'(t.ci[k]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row
    import csa_tree_pkg::*;
(
    input  acc_t a,
    input  acc_t b,
    input  acc_t c,
    input  logic cin,
    output acc_t s_o,
    output acc_t c_o
);
    logic [ACC_W-2:0] maj;

    for (genvar i = 0; i < int'(ACC_W); i++) begin : g_sum
        assign s_o[i] = a[i] ^ b[i] ^ c[i];
    end

    for (genvar i = 0; i < int'(ACC_W) - 1; i++) begin : g_maj
        assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    // shifted carry leaves bit 0 free: the pending carry-in takes it
    assign c_o = {maj, cin};

endmodule

// File: rtl/csa_tree_level.sv
module csa_tree_level
    import csa_tree_pkg::*;
#(
    parameter int unsigned LVL = 1
)(
    input  tree_t d,
    output tree_t q
);
    localparam logic [NUM_PP-1:0] USED =
        (LVL == 1) ? NUM_PP'(3)  :
        (LVL == 2) ? NUM_PP'(12) :
        (LVL == 3) ? NUM_PP'(16) : NUM_PP'(32);

    if (LVL == 1) begin : g_l1
        acc_t sa, ca, sb, cb;
        csa_row u_a (.a(d.w[0]), .b(d.w[1]), .c(d.w[2]), .cin(d.ci[0]), .s_o(sa), .c_o(ca));
        csa_row u_b (.a(d.w[3]), .b(d.w[4]), .c(d.w[5]), .cin(d.ci[1]), .s_o(sb), .c_o(cb));
        always_comb begin
            q      = '0;
            q.vld  = d.vld;
            q.ci   = d.ci & ~USED;
            q.w[0] = sa;
            q.w[1] = ca;
            q.w[2] = sb;
            q.w[3] = cb;
            q.w[4] = d.w[6];
            q.w[5] = d.w[7];
        end
    end else if (LVL == 2) begin : g_l2
        acc_t sa, ca, sb, cb;
        csa_row u_a (.a(d.w[0]), .b(d.w[1]), .c(d.w[2]), .cin(d.ci[2]), .s_o(sa), .c_o(ca));
        csa_row u_b (.a(d.w[3]), .b(d.w[4]), .c(d.w[5]), .cin(d.ci[3]), .s_o(sb), .c_o(cb));
        always_comb begin
            q      = '0;
            q.vld  = d.vld;
            q.ci   = d.ci & ~USED;
            q.w[0] = sa;
            q.w[1] = ca;
            q.w[2] = sb;
            q.w[3] = cb;
            q.w[4] = d.w[6];
            q.w[5] = d.w[7];
        end
    end else if (LVL == 3) begin : g_l3
        acc_t sa, ca;
        csa_row u_a (.a(d.w[0]), .b(d.w[1]), .c(d.w[2]), .cin(d.ci[4]), .s_o(sa), .c_o(ca));
        always_comb begin
            q      = '0;
            q.vld  = d.vld;
            q.ci   = d.ci & ~USED;
            q.w[0] = sa;
            q.w[1] = ca;
            for (int k = 0; k < 5; k++) begin
                q.w[2+k] = d.w[3+k];
            end
        end
    end else begin : g_l4
        acc_t sa, ca;
        csa_row u_a (.a(d.w[0]), .b(d.w[1]), .c(d.w[2]), .cin(d.ci[5]), .s_o(sa), .c_o(ca));
        always_comb begin
            q      = '0;
            q.vld  = d.vld;
            q.ci   = d.ci & ~USED;
            q.w[0] = sa;
            q.w[1] = ca;
            for (int k = 0; k < 5; k++) begin
                q.w[2+k] = d.w[3+k];
            end
        end
    end

endmodule

// File: rtl/csa_pipe_stage.sv
module csa_pipe_stage
    import csa_tree_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tree_t d,
    output tree_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/csa_absorb_tree.sv
module csa_absorb_tree
    import csa_tree_pkg::*;
#(
    parameter grp_e GROUPING = GRP_ONE
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [NUM_PP*PP_W-1:0]   pp_in,
    input  logic [NUM_PP-1:0]        cin_in,
    output logic                     out_vld,
    output logic [ACC_W-1:0]         sum_o,
    output logic [ACC_W-1:0]         carry_o,
    output logic [NUM_LEFT-1:0]      cin_left
);
    localparam int unsigned LVL_PER_STG = (GROUPING == GRP_ONE) ? 1 : 2;
    localparam int unsigned LAT         = NUM_LVL / LVL_PER_STG;

    tree_t lvl_d [NUM_LVL+1];
    tree_t lvl_c [NUM_LVL];

    always_comb begin
        lvl_d[0]     = '0;
        lvl_d[0].vld = in_vld;
        lvl_d[0].ci  = cin_in;
        for (int k = 0; k < int'(NUM_PP); k++) begin
            lvl_d[0].w[k] = acc_t'(pp_in[k*PP_W +: PP_W]);
        end
    end

    for (genvar g = 0; g < int'(NUM_LVL); g++) begin : g_lvl
        csa_tree_level #(.LVL(g + 1)) u_lvl (.d(lvl_d[g]), .q(lvl_c[g]));
        if (((g + 1) % LVL_PER_STG) == 0) begin : g_reg
            csa_pipe_stage u_stg (.clk(clk), .rst(rst), .d(lvl_c[g]), .q(lvl_d[g+1]));
        end else begin : g_wire
            assign lvl_d[g+1] = lvl_c[g];
        end

        // R3
        conserve_chk: assert property (@(posedge clk) disable iff (rst)
            lvl_d[g].vld |-> tree_total(lvl_d[g]) == tree_total(lvl_c[g]));
    end

    assign out_vld  = lvl_d[NUM_LVL].vld;
    assign sum_o    = lvl_d[NUM_LVL].w[0];
    assign carry_o  = lvl_d[NUM_LVL].w[1];
    assign cin_left = lvl_d[NUM_LVL].ci[NUM_PP-1 -: NUM_LEFT];

    // ---------------- assertions ----------------
    logic [3:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                warm <= '0;
        else if (warm < 4'(LAT)) warm <= warm + 4'd1;
    end

    acc_t in_total;
    acc_t out_total;
    assign in_total  = tree_total(lvl_d[0]);
    assign out_total = sum_o + carry_o + acc_t'(cin_left[0]) + acc_t'(cin_left[1]);

    // R1
    idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (warm < 4'(LAT)) |-> !out_vld);

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LAT)) |-> out_vld == $past(in_vld, LAT));

    // R3
    e2e_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LAT) && out_vld) |-> out_total == $past(in_total, LAT));

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> tree_total(lvl_d[NUM_LVL]) == out_total);

    // R4
    cin_place_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LAT) && out_vld) |->
            (carry_o[0] == $past(cin_in[5], LAT)) &&
            (cin_left == $past(cin_in[NUM_PP-1 -: NUM_LEFT], LAT)));

endmodule

// File: tb/sim_csa_absorb_tree.sv
module sim_csa_absorb_tree;
    import csa_tree_pkg::*;

    localparam int LAT = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_vld = 1'b0;
    logic [NUM_PP*PP_W-1:0] pp_in = '0;
    logic [NUM_PP-1:0]      cin_in = '0;
    logic                   out_vld;
    logic [ACC_W-1:0]       sum_o, carry_o;
    logic [NUM_LEFT-1:0]    cin_left;

    csa_absorb_tree u0 (.clk(clk), .rst(rst), .in_vld(in_vld), .pp_in(pp_in),
        .cin_in(cin_in), .out_vld(out_vld), .sum_o(sum_o), .carry_o(carry_o),
        .cin_left(cin_left));

    always #2 clk = ~clk;

    typedef struct {
        int unsigned edge_no;
        acc_t        total;
        logic        c0;
        logic [1:0]  left;
        bit          exact;
        acc_t        ex_sum;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int unsigned ecnt = 0;
    bit          done = 0;

    always @(posedge clk) ecnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [NUM_PP-1:0][PP_W-1:0] pp,
                        input logic [NUM_PP-1:0] ci,
                        input bit exact, input acc_t ex_sum);
        exp_t e;
        acc_t t;
        @(negedge clk);
        in_vld = 1'b1;
        pp_in  = pp;
        cin_in = ci;
        t = '0;
        for (int k = 0; k < int'(NUM_PP); k++) t = t + acc_t'(pp[k]) + acc_t'(ci[k]);
        e.edge_no = ecnt + LAT;
        e.total   = t;
        e.c0      = ci[5];
        e.left    = {ci[7], ci[6]};
        e.exact   = exact;
        e.ex_sum  = ex_sum;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            pp_in  = {$urandom, $urandom, $urandom};
            cin_in = NUM_PP'($urandom);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                acc_t got;
                e   = sb.pop_front();
                got = sum_o + carry_o + acc_t'(cin_left[0]) + acc_t'(cin_left[1]);
                chk(ecnt == e.edge_no, "R2", "result edge", ecnt, e.edge_no);
                chk(got == e.total, "R3", "redundant total", got, e.total);
                chk(carry_o[0] == e.c0, "R4", "carry lsb", carry_o[0], e.c0);
                chk(cin_left == e.left, "R4", "leftover cins", cin_left, e.left);
                if (e.exact) begin
                    chk(sum_o == e.ex_sum, "R6", "lone sum", sum_o, e.ex_sum);
                    chk(carry_o == '0, "R6", "lone carry", carry_o, 0);
                end
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        logic [NUM_PP-1:0][PP_W-1:0] pp;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld in reset", out_vld, 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
        end

        // R6: lone operand in slots 0, 3, 7
        pp = '0; pp[0] = PP_W'(10'h2A5); send(pp, '0, 1, acc_t'(pp[0]));
        pp = '0; pp[3] = PP_W'(10'h3FF); send(pp, '0, 1, acc_t'(pp[3]));
        pp = '0; pp[7] = PP_W'(10'h155); send(pp, '0, 1, acc_t'(pp[7]));

        // R8: everything at maximum wraps to zero
        pp = '1; send(pp, '1, 0, '0);
        // R4: carry-in placement
        pp = '0; send(pp, NUM_PP'(8'h20), 0, '0);
        pp = '0; send(pp, NUM_PP'(8'hC0), 0, '0);
        pp = '0; send(pp, NUM_PP'(8'h40), 0, '0);

        // R7: idle junk
        idle(LAT + 2);
        @(negedge clk);
        chk(out_vld == 1'b0, "R7", "idle out_vld", out_vld, 0);
        chk(sb.size() == 0, "R5", "drained queue", sb.size(), 0);

        // R5, R3: back-to-back random items
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < int'(NUM_PP); k++) pp[k] = PP_W'($urandom);
            send(pp, NUM_PP'($urandom), 0, '0);
        end
        // mixed with gaps
        for (int n = 0; n < 20; n++) begin
            for (int k = 0; k < int'(NUM_PP); k++) pp[k] = PP_W'($urandom);
            send(pp, NUM_PP'($urandom), 0, '0);
            if (n % 3 == 0) idle(1 + (n % 4));
        end
        idle(LAT + 3);
        chk(out_vld == 1'b0, "R7", "final idle out_vld", out_vld, 0);
        chk(sb.size() == 0, "R5", "all results seen", sb.size(), 0);
        done = 1;
        finish_run();
    end

endmodule